// File: doc/BRIEF.md
# ADC Result Offset and Alignment Formatter

This block turns a raw 12-bit conversion result into a 16-bit data word that is ready to store. There are two channel groups. For a result from the injected group, the block subtracts a per-channel offset. That result is signed, so the block sign-extends it. A result from the regular group passes through unchanged, and any offset on the input is ignored.

An alignment select places the significant bits at the bottom or at the top of the 16-bit word. The left-justified layouts differ between the groups. An injected result keeps its sign in the top bit and shifts by three positions. A regular result shifts by four positions.

The converter drives the raw value, the group, the offset and the alignment together with a single-cycle valid strobe. The formatted word and a one-cycle valid pulse appear on the next clock edge. The word then stays unchanged until the next strobe.

Top module: `adc_result_formatter`

## Requirements
- R1: While rst_ni is low, and right after it is released, data_o is 16'h0000 and valid_o is 0.
- R2: valid_o is 1 in exactly the cycle after each cycle in which valid_i is 1, and 0 otherwise. Back-to-back strobes give back-to-back pulses, each with its own data.
- R3: data_o changes only on the clock edge that follows a cycle with valid_i = 1. Changes on raw_i, offset_i, grp_inj_i or align_left_i while valid_i = 0 have no effect on the output.
- R4: Regular group (grp_inj_i = 0) with right alignment (align_left_i = 0): data_o = {4'b0000, raw_i}. The offset is not applied.
- R5: Regular group with left alignment (align_left_i = 1): data_o = {raw_i, 4'b0000}. The offset is not applied.
- R6: Injected group (grp_inj_i = 1): the block forms a 13-bit two's-complement difference d = raw_i - offset_i, where both operands are unsigned. The sign is d[12], and d[11:0] is the 12-bit payload. The difference is never saturated. When it underflows, the payload keeps its wrapped two's-complement form.
- R7: Injected group with right alignment: data_o = {4{d[12]}, d[11:0]}.
- R8: Injected group with left alignment: data_o = {d[12], d[11:0], 3'b000}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Single-cycle strobe; the other inputs are sampled when it is 1 |
| grp_inj_i | input | 1 | Group select: 1 = injected, 0 = regular |
| align_left_i | input | 1 | Alignment: 1 = left-justified, 0 = right-justified |
| raw_i | input | 12 | Raw conversion result |
| offset_i | input | 12 | Unsigned offset for the channel; used only by the injected group |
| valid_o | output | 1 | One-cycle pulse marking a new value on data_o |
| data_o | output | 16 | Formatted result word |

## Verification
The bench builds the block with its default widths: a 12-bit result in a 16-bit word. With these widths the injected left layout has exactly three zero fill bits and the sign bit on top, and the regular layout has four pad bits.

The vector table covers each group under both alignments. It includes offsets equal to, smaller than and larger than the raw value, so zero, positive, slightly negative and fully underflowed differences all reach the sign-extension path. It also includes a regular-group vector with a large offset, to show that the offset is ignored for that group.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  localparam int unsigned RES_W = 12;
  localparam int unsigned OUT_W = 16;

  typedef enum logic {
    GRP_REGULAR  = 1'b0,
    GRP_INJECTED = 1'b1
  } grp_e;

  typedef enum logic {
    ALIGN_RIGHT = 1'b0,
    ALIGN_LEFT  = 1'b1
  } align_e;
endpackage

// File: rtl/adc_fmt_offset.sv
module adc_fmt_offset
  import adc_fmt_pkg::*;
#(
  parameter int unsigned RES_W = adc_fmt_pkg::RES_W
) (
  input  grp_e             grp_i,
  input  logic [RES_W-1:0] raw_i,
  input  logic [RES_W-1:0] offset_i,
  output logic             sign_o,
  output logic [RES_W-1:0] mag_o
);
  logic [RES_W-1:0] off_eff;
  logic [RES_W:0]   diff;

  // regular group sees a zero offset, so its sign is always clear
  assign off_eff = (grp_i == GRP_INJECTED) ? offset_i : '0;
  assign diff    = {1'b0, raw_i} - {1'b0, off_eff};
  assign sign_o  = diff[RES_W];
  assign mag_o   = diff[RES_W-1:0];
endmodule

// File: rtl/adc_fmt_align.sv
module adc_fmt_align
  import adc_fmt_pkg::*;
#(
  parameter int unsigned RES_W = adc_fmt_pkg::RES_W,
  parameter int unsigned OUT_W = adc_fmt_pkg::OUT_W
) (
  input  grp_e             grp_i,
  input  align_e           align_i,
  input  logic             sign_i,
  input  logic [RES_W-1:0] mag_i,
  output logic [OUT_W-1:0] word_o
);
  // OUT_W must be at least RES_W + 2
  localparam int unsigned PAD_W  = OUT_W - RES_W;
  localparam int unsigned INJ_SH = PAD_W - 1;
  localparam int unsigned REG_SH = PAD_W;

  logic [OUT_W-1:0] inj_right, inj_left, reg_right, reg_left;

  assign inj_right = {{PAD_W{sign_i}}, mag_i};
  assign inj_left  = {sign_i, mag_i, {INJ_SH{1'b0}}};
  assign reg_right = {{PAD_W{1'b0}}, mag_i};
  assign reg_left  = {mag_i, {REG_SH{1'b0}}};

  always_comb begin
    unique case ({grp_i, align_i})
      {GRP_INJECTED, ALIGN_LEFT}:  word_o = inj_left;
      {GRP_INJECTED, ALIGN_RIGHT}: word_o = inj_right;
      {GRP_REGULAR,  ALIGN_LEFT}:  word_o = reg_left;
      default:                     word_o = reg_right;
    endcase
  end
endmodule

// File: rtl/adc_result_formatter.sv
module adc_result_formatter
  import adc_fmt_pkg::*;
#(
  parameter int unsigned RES_W = adc_fmt_pkg::RES_W,
  parameter int unsigned OUT_W = adc_fmt_pkg::OUT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             grp_inj_i,
  input  logic             align_left_i,
  input  logic [RES_W-1:0] raw_i,
  input  logic [RES_W-1:0] offset_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] data_o
);
  grp_e             grp;
  align_e           align;
  logic             sign;
  logic [RES_W-1:0] mag;
  logic [OUT_W-1:0] word_d;
  logic [OUT_W-1:0] data_q;
  logic             valid_q;

  assign grp   = grp_e'(grp_inj_i);
  assign align = align_e'(align_left_i);

  adc_fmt_offset #(.RES_W(RES_W)) u_offset (
    .grp_i    (grp),
    .raw_i    (raw_i),
    .offset_i (offset_i),
    .sign_o   (sign),
    .mag_o    (mag)
  );

  adc_fmt_align #(.RES_W(RES_W), .OUT_W(OUT_W)) u_align (
    .grp_i   (grp),
    .align_i (align),
    .sign_i  (sign),
    .mag_i   (mag),
    .word_o  (word_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) data_q <= word_d;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/adc_fmt_checker.sv
module adc_fmt_checker #(
  parameter int unsigned RES_W = 12,
  parameter int unsigned OUT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             grp_inj_i,
  input logic             align_left_i,
  input logic [RES_W-1:0] raw_i,
  input logic [RES_W-1:0] offset_i,
  input logic             valid_o,
  input logic [OUT_W-1:0] data_o
);
  localparam int unsigned PAD_W = OUT_W - RES_W;

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o) else $error("valid pulse missing"); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o) else $error("spurious valid"); // R2
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o)) else $error("data moved without strobe"); // R3
  AST_REG_RIGHT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !grp_inj_i && !align_left_i) |=>
      (data_o == {{PAD_W{1'b0}}, $past(raw_i)})) else $error("regular right"); // R4
  AST_REG_LEFT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !grp_inj_i && align_left_i) |=>
      (data_o == {$past(raw_i), {PAD_W{1'b0}}})) else $error("regular left"); // R5
  AST_INJ_RIGHT_PAYLOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && grp_inj_i && !align_left_i) |=>
      (data_o[RES_W-1:0] == RES_W'($past(raw_i) - $past(offset_i)))) else $error("inj payload"); // R6
  AST_INJ_RIGHT_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && grp_inj_i && !align_left_i) |=>
      (data_o[OUT_W-1:RES_W] == '0 || data_o[OUT_W-1:RES_W] == '1)) else $error("inj sign ext"); // R7
  AST_INJ_LEFT_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && grp_inj_i && align_left_i) |=>
      (data_o[PAD_W-2:0] == '0)) else $error("inj left fill"); // R8
endmodule

bind adc_result_formatter adc_fmt_checker #(.RES_W(RES_W), .OUT_W(OUT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .grp_inj_i    (grp_inj_i),
  .align_left_i (align_left_i),
  .raw_i        (raw_i),
  .offset_i     (offset_i),
  .valid_o      (valid_o),
  .data_o       (data_o)
);

// File: tb/adc_result_formatter_bench.sv
`timescale 1ns/1ps
module adc_result_formatter_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        grp_inj_i = 1'b0;
  logic        align_left_i = 1'b0;
  logic [11:0] raw_i = '0;
  logic [11:0] offset_i = '0;
  logic        valid_o;
  logic [15:0] data_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  adc_result_formatter u_adc_result_formatter (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .grp_inj_i(grp_inj_i),
    .align_left_i(align_left_i), .raw_i(raw_i), .offset_i(offset_i),
    .valid_o(valid_o), .data_o(data_o)
  );

  // {grp, align, raw, offset, expected}
  localparam int NV = 13;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 1'b0, 12'hABC, 12'h123, 16'h0ABC}, // R4
    {1'b0, 1'b1, 12'hABC, 12'h123, 16'hABC0}, // R5
    {1'b0, 1'b0, 12'hFFF, 12'hFFF, 16'h0FFF}, // R4 offset ignored
    {1'b0, 1'b1, 12'h001, 12'h000, 16'h0010}, // R5
    {1'b1, 1'b0, 12'h100, 12'h200, 16'hFF00}, // R7 negative
    {1'b1, 1'b1, 12'h100, 12'h200, 16'hF800}, // R8 negative
    {1'b1, 1'b0, 12'hFFF, 12'h000, 16'h0FFF}, // R7 positive, D11 set
    {1'b1, 1'b1, 12'hFFF, 12'h000, 16'h7FF8}, // R8
    {1'b1, 1'b0, 12'h000, 12'hFFF, 16'hF001}, // R6 full underflow
    {1'b1, 1'b1, 12'h000, 12'hFFF, 16'h8008}, // R6
    {1'b1, 1'b0, 12'h800, 12'h100, 16'h0700}, // R7
    {1'b1, 1'b1, 12'h800, 12'h100, 16'h3800}, // R8
    {1'b1, 1'b0, 12'h555, 12'h555, 16'h0000}  // R6 zero difference
  };
  localparam int TAG [NV] = '{4, 5, 4, 5, 7, 8, 7, 8, 6, 6, 7, 8, 6};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic g, input logic a, input logic [11:0] r, input logic [11:0] o);
    grp_inj_i = g; align_left_i = a; raw_i = r; offset_i = o; valid_i = 1'b1;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 data in reset", data_o, 16'h0000);
    check("R1 valid in reset", {15'b0, valid_o}, 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 data after release", data_o, 16'h0000);
    check("R1 valid after release", {15'b0, valid_o}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][41], VEC[i][40], VEC[i][39:28], VEC[i][27:16]);
      @(negedge clk_i);
      valid_i = 1'b0;
      check($sformatf("R%0d vector %0d", TAG[i], i), data_o, VEC[i][15:0]);
      check("R2 valid pulse", {15'b0, valid_o}, 16'h0001);
      @(negedge clk_i);
      check("R2 valid drops", {15'b0, valid_o}, 16'h0000);
    end

    // R3: inputs change with no strobe
    drive(1'b0, 1'b0, 12'h123, 12'h000);
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R4 before hold", data_o, 16'h0123);
    grp_inj_i = 1'b1; align_left_i = 1'b1; raw_i = 12'h000; offset_i = 12'hFFF;
    repeat (3) @(negedge clk_i);
    check("R3 data held", data_o, 16'h0123);
    check("R3 no valid", {15'b0, valid_o}, 16'h0000);

    // R2: back-to-back strobes
    drive(1'b1, 1'b0, 12'h010, 12'h020);
    @(negedge clk_i);
    check("R7 first of pair", data_o, 16'hFFF0);
    check("R2 first pulse", {15'b0, valid_o}, 16'h0001);
    drive(1'b0, 1'b1, 12'h010, 12'h020);
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R5 second of pair", data_o, 16'h0100);
    check("R2 second pulse", {15'b0, valid_o}, 16'h0001);

    // R1: reset mid-run
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 data after mid reset", data_o, 16'h0000);
    check("R1 valid after mid reset", {15'b0, valid_o}, 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule